// File: doc/BRIEF.md
# Serial Command Register Bridge

A host reaches this block over one asynchronous serial line. The block holds a small file of byte-wide registers and is controlled by single-byte commands. Each command byte carries a register address in its upper nibble and an operation code in its lower nibble. A read command makes the block send back one byte holding the addressed register. A write command takes the next byte that arrives on the line as the value to store. Register 0 is a fixed identification byte that cannot be changed.

The block has three parts. A serial receiver synchronizes the input, checks each start bit at its centre and delivers whole bytes. A command decoder has two states, `DEC_CMD` and `DEC_DATA`, and holds the registers and one pending reply. A serial transmitter sends each reply as an 8N1 frame. The receiver steps through `RX_IDLE` → `RX_START` (half a bit, then it checks the line or drops back to `RX_IDLE`) → `RX_DATA` (eight bit times) → `RX_STOP` (one bit time, then it delivers the byte) → `RX_IDLE`. The transmitter steps through `TX_IDLE` → `TX_START` → `TX_DATA` (eight bits) → `TX_STOP`. From `TX_STOP` it goes back to `TX_IDLE`, or goes straight to `TX_START` when a reply is waiting. The decoder moves from `DEC_CMD` to `DEC_DATA` on a valid write command and back to `DEC_CMD` on the next byte.

The bit time is `CLK_HZ / BAUD` clock cycles. The defaults are 10 MHz and 9600 baud, which gives 1041 cycles per bit.

Top module: `uart_cmd_bridge`

## Requirements
- R1: Each reply is sent as one low start bit, then eight data bits with the least significant bit first, then one high stop bit. Every bit lasts `CLK_HZ/BAUD` clock cycles.
- R2: The receiver checks a falling edge half a bit time later. If the line is high again by then, the edge is discarded and no byte results, even while a write is waiting for its data byte.
- R3: In a command byte, bits 7:4 are the register address and bits 3:0 are the operation: 0x0 is read and 0x1 is write.
- R4: Each valid read command produces exactly one reply byte, holding the addressed register's contents at the moment the command is received.
- R5: A valid write command stores the next received byte into the addressed register and produces no reply.
- R6: Register 0 always reads 0x01, and writes to it have no effect.
- R7: Registers 1 to 7 read 0x00 after reset, and afterwards they read back the last value written to them.
- R8: A command whose address is 8 to 15, or whose operation is neither 0x0 nor 0x1, produces no reply and consumes no data byte. The next byte is taken as a new command.
- R9: A read that completes while a reply is being sent is held. Its frame starts exactly one frame time (10 bit times) after the previous frame's start, so replies are neither dropped nor overlapped.
- R10: The transmit line is high during reset, and it stays high at all times when no reply is owed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial command input, idles high |
| txd_o | output | 1 | Serial reply output, idles high |

## Verification
If a state machine is wrong inside the block, it shows up on the reply line within one frame time. A decoder left in `DEC_DATA` turns the next read into a silent write, so the expected reply goes missing. A receiver that takes a glitch as a start bit shifts the framing, so a later reply carries the wrong value or appears when none is owed. The bench keeps an expected-reply queue and a model of the registers. On every clock it checks that the line is idle when no reply is owed. It also checks each decoded frame's start bit, stop bit and value, and for back-to-back reads it checks the exact spacing between frame starts.

// File: rtl/uart_bridge_pkg.sv
package uart_bridge_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic {
        DEC_CMD,
        DEC_DATA
    } dec_state_e;

    localparam logic [3:0] OP_READ  = 4'h0;
    localparam logic [3:0] OP_WRITE = 4'h1;

endpackage

// File: rtl/uart_rx_unit.sv
module uart_rx_unit
    import uart_bridge_pkg::*;
#(
    parameter int CPB = 1041,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o
);

    localparam int CW   = (CPB > 2) ? $clog2(CPB) : 2;
    localparam int BW   = $clog2(DW);
    localparam int HALF = CPB / 2;

    rx_state_e     state, state_n;
    logic          sync1, sync2, line_prev;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bit_idx;
    logic [DW-1:0] shreg;
    logic          fall, cnt_last, half_last, bit_last;

    // two-flop synchronizer plus edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1     <= 1'b1;
            sync2     <= 1'b1;
            line_prev <= 1'b1;
        end else begin
            sync1     <= rxd_i;
            sync2     <= sync1;
            line_prev <= sync2;
        end
    end

    assign fall      = line_prev & ~sync2;
    assign cnt_last  = (cnt == CW'(CPB - 1));
    assign half_last = (cnt == CW'(HALF - 1));
    assign bit_last  = (bit_idx == BW'(DW - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:  if (fall) state_n = RX_START;
            RX_START: if (half_last) state_n = sync2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (cnt_last && bit_last) state_n = RX_STOP;
            RX_STOP:  if (cnt_last) state_n = RX_IDLE;
            default:  state_n = RX_IDLE;
        endcase
    end

    // counters, shifter and byte output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state_n != state) begin
                cnt <= '0;
            end else if (state == RX_DATA && cnt_last) begin
                cnt <= '0;
            end else if (state != RX_IDLE) begin
                cnt <= cnt + CW'(1);
            end
            if (state == RX_START) begin
                bit_idx <= '0;
            end else if (state == RX_DATA && cnt_last) begin
                shreg   <= {sync2, shreg[DW-1:1]};
                bit_idx <= bit_idx + BW'(1);
            end
            if (state == RX_STOP && cnt_last) begin
                data_o  <= shreg;
                valid_o <= 1'b1;
            end
        end
    end

    // R2: a delivered byte is a single-cycle pulse
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R2: a start that is found high again at its centre yields no byte
    a_r2_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && half_last && sync2) |=> (state == RX_IDLE && !valid_o));

endmodule

// File: rtl/uart_tx_unit.sv
module uart_tx_unit
    import uart_bridge_pkg::*;
#(
    parameter int CPB = 1041,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] data_i,
    output logic          ready_o,
    output logic          txd_o
);

    localparam int CW = (CPB > 2) ? $clog2(CPB) : 2;
    localparam int BW = $clog2(DW);

    tx_state_e     state, state_n;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bit_idx;
    logic [DW-1:0] shreg;
    logic          cnt_last, bit_last, line_n;

    assign cnt_last = (cnt == CW'(CPB - 1));
    assign bit_last = (bit_idx == BW'(DW - 1));
    assign ready_o  = (state == TX_IDLE) || (state == TX_STOP && cnt_last);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            TX_IDLE:  if (start_i) state_n = TX_START;
            TX_START: if (cnt_last) state_n = TX_DATA;
            TX_DATA:  if (cnt_last && bit_last) state_n = TX_STOP;
            TX_STOP:  if (cnt_last) state_n = start_i ? TX_START : TX_IDLE;
            default:  state_n = TX_IDLE;
        endcase
    end

    // line level for the current state
    always_comb begin
        unique case (state)
            TX_START: line_n = 1'b0;
            TX_DATA:  line_n = shreg[0];
            default:  line_n = 1'b1;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            txd_o   <= 1'b1;
        end else begin
            txd_o <= line_n;
            if (cnt_last || state == TX_IDLE) cnt <= '0;
            else                              cnt <= cnt + CW'(1);
            if (ready_o && start_i) begin
                shreg   <= data_i;
                bit_idx <= '0;
            end else if (state == TX_DATA && cnt_last) begin
                shreg   <= {1'b0, shreg[DW-1:1]};
                bit_idx <= bit_idx + BW'(1);
            end
        end
    end

    // R1: start bit drives the line low
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START) |=> !txd_o);

    // R1: stop bit drives the line high
    a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP) |=> txd_o);

    // R10: idle transmitter keeps the line high
    a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) |=> txd_o);

endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import uart_bridge_pkg::*;
#(
    parameter int             DW       = 8,
    parameter int             NREGS    = 8,
    parameter logic [DW-1:0]  ID_VALUE = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rx_data_i,
    input  logic          rx_valid_i,
    input  logic          tx_ready_i,
    output logic          tx_start_o,
    output logic [DW-1:0] tx_data_o
);

    localparam int AW = $clog2(NREGS);
    localparam int NW = DW / 2;

    dec_state_e    st, st_n;
    logic [DW-1:0] regs [NREGS];
    logic [NW-1:0] c_addr, c_op;
    logic          c_addr_ok, rd_hit, wr_cmd, wr_hit;
    logic [AW-1:0] wr_addr;
    logic          pend_valid;
    logic [DW-1:0] pend_data;

    // R3: field split of a command byte
    assign c_addr    = rx_data_i[DW-1:NW];
    assign c_op      = rx_data_i[NW-1:0];
    assign c_addr_ok = (int'(c_addr) < NREGS);
    assign rd_hit    = (st == DEC_CMD) && rx_valid_i && c_addr_ok && (c_op == OP_READ);
    assign wr_cmd    = (st == DEC_CMD) && rx_valid_i && c_addr_ok && (c_op == OP_WRITE);
    assign wr_hit    = (st == DEC_DATA) && rx_valid_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= DEC_CMD;
        else        st <= st_n;
    end

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            DEC_CMD:  if (wr_cmd) st_n = DEC_DATA;
            DEC_DATA: if (rx_valid_i) st_n = DEC_CMD;
            default:  st_n = DEC_CMD;
        endcase
    end

    // register file: slot 0 is fixed
    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        if (gi == 0) begin : g_id
            assign regs[gi] = ID_VALUE;
        end else begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 q <= '0;
                else if (wr_hit && wr_addr == AW'(gi))      q <= rx_data_i;
            end
            assign regs[gi] = q;
        end
    end

    // write address latch and one-deep reply holding slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr    <= '0;
            pend_valid <= 1'b0;
            pend_data  <= '0;
        end else begin
            if (wr_cmd) wr_addr <= c_addr[AW-1:0];
            if (rd_hit) begin
                pend_valid <= 1'b1;
                pend_data  <= regs[c_addr[AW-1:0]];
            end else if (tx_start_o) begin
                pend_valid <= 1'b0;
            end
        end
    end

    assign tx_start_o = pend_valid && tx_ready_i;
    assign tx_data_o  = pend_data;

    // R9: a held reply is never overwritten by a newer read
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hit && pend_valid && !tx_ready_i));

    // R5: the data byte of a write does not create a reply
    a_r5_wr_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !pend_valid) |=> !pend_valid);

    // R8: a rejected command leaves the decoder waiting for a command
    a_r8_bad_cmd_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DEC_CMD && rx_valid_i && !rd_hit && !wr_cmd) |=> (st == DEC_CMD));

endmodule

// File: rtl/uart_cmd_bridge.sv
module uart_cmd_bridge #(
    parameter int          CLK_HZ   = 10_000_000,
    parameter int          BAUD     = 9600,
    parameter int          NREGS    = 8,
    parameter logic [7:0]  ID_VALUE = 8'h01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    output logic txd_o
);

    localparam int CPB = CLK_HZ / BAUD;
    localparam int DW  = 8;

    logic [DW-1:0] rx_data, tx_data;
    logic          rx_valid, tx_ready, tx_start;

    uart_rx_unit #(.CPB(CPB), .DW(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_i   (rxd_i),
        .data_o  (rx_data),
        .valid_o (rx_valid)
    );

    cmd_decoder #(.DW(DW), .NREGS(NREGS), .ID_VALUE(ID_VALUE)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data_i  (rx_data),
        .rx_valid_i (rx_valid),
        .tx_ready_i (tx_ready),
        .tx_start_o (tx_start),
        .tx_data_o  (tx_data)
    );

    uart_tx_unit #(.CPB(CPB), .DW(DW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .data_i  (tx_data),
        .ready_o (tx_ready),
        .txd_o   (txd_o)
    );

endmodule

// File: tb/uart_cmd_bridge_test.sv
module uart_cmd_bridge_test;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic txd;

    int n_checks = 0;
    int n_fail = 0;
    int idle_err = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_busy = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] model[8];
    int starts[$];

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_cmd_bridge #(.CLK_HZ(BIT_CYC * 10), .BAUD(10)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd_i (rxd),
        .txd_o (txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int stop_cyc = BIT_CYC);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT_CYC - 1) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) rxd = b[i];
            repeat (BIT_CYC - 1) @(negedge clk);
        end
        @(negedge clk) rxd = 1'b1;
        repeat (stop_cyc - 1) @(negedge clk);
    endtask

    task automatic send_read(input int a, input int stop_cyc = BIT_CYC);
        exp_q.push_back(model[a]);
        send_byte({a[3:0], 4'h0}, stop_cyc);
    endtask

    task automatic send_write(input int a, input logic [7:0] d);
        send_byte({a[3:0], 4'h1});
        send_byte(d);
        if (a != 0) model[a] = d;
    endtask

    task automatic glitch(input int len);
        @(negedge clk) rxd = 1'b0;
        repeat (len) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 40 * BIT_CYC; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !mon_busy) break;
        end
        repeat (2 * BIT_CYC) @(negedge clk);
    endtask

    // reply monitor: decodes frames on the transmit line (R1, R4)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !mon_busy && txd === 1'b0) begin
                logic [7:0] got;
                logic start_ok, stop_ok;
                mon_busy = 1'b1;
                starts.push_back(cyc);
                repeat (BIT_CYC / 2) @(negedge clk);
                start_ok = (txd === 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BIT_CYC) @(negedge clk);
                stop_ok = (txd === 1'b1);
                check(start_ok && stop_ok, "R1 frame start/stop", {start_ok, stop_ok}, 2'b11);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4/R8 unexpected reply", got, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(got === e, "R4 reply value", got, e);
                end
                mon_busy = 1'b0;
            end
        end
    end

    // per-clock reference comparison: line must be idle when nothing is owed (R10, R5)
    always @(negedge clk) begin
        if (!mon_busy && exp_q.size() == 0 && txd !== 1'b1) idle_err++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = (i == 0) ? 8'h01 : 8'h00;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(txd === 1'b1, "R10 line high in reset", txd, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(txd === 1'b1, "R10 line high after reset", txd, 1);

        // R3 R6 R7: reset values read over the link
        for (int a = 0; a < 8; a++) send_read(a);
        drain();

        // R5 R6 R7: write all-ones everywhere, no replies
        for (int a = 0; a < 8; a++) send_write(a, 8'hFF);
        drain();
        check(idle_err == 0, "R5 no reply to writes", idle_err, 0);
        for (int a = 0; a < 8; a++) send_read(a);
        drain();

        // R7: distinct values, R6: write to id register ignored
        send_write(3, 8'hA5);
        send_write(5, 8'h3C);
        send_write(0, 8'h77);
        send_read(0);
        send_read(3);
        send_read(5);
        drain();

        // R8: out-of-range addresses and unknown opcodes
        send_byte(8'h80);
        send_byte(8'h13);
        drain();
        check(idle_err == 0, "R8 no reply to bad commands", idle_err, 0);
        send_byte(8'hF1);
        send_read(2);
        send_byte(8'h22);
        send_read(4);
        drain();
        send_read(3);
        drain();

        // R2: glitch while a write waits for data
        send_byte(8'h61);
        glitch(3);
        send_byte(8'h5E);
        model[6] = 8'h5E;
        send_read(6);
        drain();
        glitch(5);
        send_read(6);
        drain();

        // R9: reads sent with shortened stop bits so replies must be held
        starts.delete();
        send_read(1, BIT_CYC / 2 + 2);
        send_read(3, BIT_CYC / 2 + 2);
        send_read(5, BIT_CYC / 2 + 2);
        send_read(0, BIT_CYC / 2 + 2);
        drain();
        check(starts.size() == 4, "R9 reply count", starts.size(), 4);
        for (int i = 1; i < starts.size(); i++)
            check(starts[i] - starts[i-1] == 10 * BIT_CYC, "R9 back-to-back spacing",
                  starts[i] - starts[i-1], 10 * BIT_CYC);

        check(exp_q.size() == 0, "R4 all replies received", exp_q.size(), 0);
        check(idle_err == 0, "R10 idle line when no reply owed", idle_err, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule